// File: doc/BRIEF.md
# Wait-State Memory Bus Master

This block drives a simple parallel memory bus: 16-bit address and 8-bit data. A core hands it one transfer at a time through a valid/ready handshake. Each transfer carries an address, a direction and, for writes, a data byte. The block then runs one bus cycle and returns a one-cycle response. The response carries the read byte and an error flag.

A bus cycle is at least two clocks long. The first clock is the address phase and the second is the data phase. The direction line is high for a read and low for a write. A valid-address qualifier is high through both phases. Write data is driven only in the data phase, which is after the address and qualifier have been presented. Three parameterised address windows produce one-hot chip selects, and these selects are gated by the qualifier.

A slow peripheral can pull the ready line low. Each clock on which ready is sampled low adds one whole wait cycle, and the bus clock itself is never stretched. The number of added wait cycles has an upper bound. This bound is a parameter, and its default is 10 µs at 50 MHz. When the bound is reached, the cycle is ended with an error and the read value is forced to all ones.

Top module: `bus_stall_master`

## Requirements
- R1: While reset is held and on the first cycle after reset, `bus_vma`=0, `chip_sel`=0, `bus_dout_en`=0, `rsp_valid`=0 and `req_ready`=1.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. On the next cycle (the address phase), `bus_vma`=1, `bus_addr` equals the request address, and `bus_rnw`=1 for a read or 0 for a write.
- R3: `bus_dout_en` is 1 only during data-phase cycles of a write, and `bus_dout` then carries the write byte. It is never 1 in the address phase or during a read.
- R4: `chip_sel` is one-hot or zero and is nonzero only while `bus_vma`=1. Bit 0 covers 0x0000–0x1FFF, bit 1 covers 0x8000–0x80FF and bit 2 covers 0xE000–0xFFFF (inclusive). If windows overlap, the lowest index wins. An address outside all windows selects nothing.
- R5: `mem_rdy` is sampled on each data-phase clock edge. When it is seen high, the cycle ends. For a read, `rsp_rdata` equals `bus_din` as sampled on that edge, and `rsp_err`=0. With `mem_rdy` always high, a cycle takes exactly one address and one data clock.
- R6: Each data-phase edge with `mem_rdy`=0 adds one wait cycle. During the wait cycles, `bus_addr`, `bus_rnw`, `bus_vma` and `chip_sel` hold their values. A stall of k low samples with k ≤ MAX_WAIT still completes without error after k+1 data clocks.
- R7: If `mem_rdy` is still 0 after MAX_WAIT wait cycles (MAX_WAIT+1 data clocks), the cycle ends with `rsp_err`=1 and `rsp_rdata`=0xFF, for both reads and writes.
- R8: `rsp_valid` is a one-cycle pulse on the cycle after the data phase ends. On that cycle `bus_vma`=0 and `chip_sel`=0. `req_ready` is 0 from the address phase through the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core offers a transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Block can accept a transfer |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read byte (0xFF on timeout) |
| rsp_err | output | 1 | Cycle ended by stall timeout |
| bus_addr | output | 16 | Bus address |
| bus_rnw | output | 1 | Direction: 1 read, 0 write |
| bus_vma | output | 1 | Valid-address qualifier |
| bus_dout | output | 8 | Write data to bus |
| bus_dout_en | output | 1 | Write data drive enable |
| bus_din | input | 8 | Read data from bus |
| mem_rdy | input | 1 | Ready; low inserts wait cycles |
| chip_sel | output | 3 | Qualified one-hot window selects |

## Verification
Addresses are chosen at both edges of every window and just outside them. This separates an inclusive compare from an off-by-one compare, and it shows whether the unmapped gaps between windows select anything. Stall lengths are swept from zero, through exactly MAX_WAIT, to beyond it. This separates a completed stall from a timeout and exposes an off-by-one in the limit. Random mixes of direction, window and stall length, run back to back with the request held high, check that data is driven in the right phase, that read data is taken on the edge where ready is seen high, and that there is an idle gap between cycles.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_DONE = 2'd3
  } bsm_state_e;

  // Inclusive window compare on a bus address.
  function automatic logic fn_in_window(input logic [15:0] a,
                                        input logic [15:0] lo,
                                        input logic [15:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // Width needed to count 0..limit.
  function automatic int fn_cnt_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  // Value returned when a cycle is abandoned.
  function automatic logic [7:0] fn_abort_data();
    return 8'hFF;
  endfunction

endpackage

// File: rtl/bsm_addr_decode.sv
module bsm_addr_decode #(
  parameter int          ADDR_W = 16,
  parameter int          NREG   = 3,
  parameter logic [NREG*ADDR_W-1:0] WIN_LO = {16'hE000, 16'h8000, 16'h0000},
  parameter logic [NREG*ADDR_W-1:0] WIN_HI = {16'hFFFF, 16'h80FF, 16'h1FFF}
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              qual,
  output logic [NREG-1:0]   sel
);
  import bsm_pkg::*;

  logic [NREG-1:0] raw_hit;
  logic [NREG:0]   taken;

  assign taken[0] = 1'b0;

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_win
      assign raw_hit[i]  = fn_in_window(addr,
                                        WIN_LO[i*ADDR_W +: ADDR_W],
                                        WIN_HI[i*ADDR_W +: ADDR_W]);
      assign sel[i]      = qual && raw_hit[i] && !taken[i];
      assign taken[i+1]  = taken[i] | raw_hit[i];
    end
  endgenerate

endmodule

// File: rtl/bsm_wait_timer.sv
module bsm_wait_timer #(
  parameter int MAX_WAIT = 500,
  localparam int CW = bsm_pkg::fn_cnt_width(MAX_WAIT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          stall,
  output logic [CW-1:0] waits,
  output logic          at_limit
);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      waits <= '0;
    end else if (stall && waits != LIMIT) begin
      waits <= waits + 1'b1;
    end
  end

  assign at_limit = (waits == LIMIT);

endmodule

// File: rtl/bsm_seq.sv
module bsm_seq #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              mem_rdy,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              tmo_hit,
  output bsm_pkg::bsm_state_e st,
  output logic              accept,
  output logic [ADDR_W-1:0] addr_q,
  output logic              rnw_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              err_q
);
  import bsm_pkg::*;

  bsm_state_e st_nx;
  logic       fin_ok;
  logic       fin_tmo;

  assign accept  = (st == ST_IDLE) && req_valid;
  assign fin_ok  = (st == ST_DATA) && mem_rdy;
  assign fin_tmo = (st == ST_DATA) && !mem_rdy && tmo_hit;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: if (accept) st_nx = ST_ADDR;
      ST_ADDR: st_nx = ST_DATA;
      ST_DATA: if (fin_ok || fin_tmo) st_nx = ST_DONE;
      ST_DONE: st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      addr_q  <= '0;
      rnw_q   <= 1'b1;
      wdata_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      st <= st_nx;
      if (accept) begin
        addr_q  <= req_addr;
        rnw_q   <= !req_write;
        wdata_q <= req_wdata;
      end
      if (fin_ok) begin
        rdata_q <= rnw_q ? bus_din : '0;
        err_q   <= 1'b0;
      end else if (fin_tmo) begin
        rdata_q <= DATA_W'(fn_abort_data());
        err_q   <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/bus_stall_master.sv
module bus_stall_master #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int NREG     = 3,
  parameter int MAX_WAIT = 500,
  parameter logic [NREG*ADDR_W-1:0] WIN_LO = {16'hE000, 16'h8000, 16'h0000},
  parameter logic [NREG*ADDR_W-1:0] WIN_HI = {16'hFFFF, 16'h80FF, 16'h1FFF}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rnw,
  output logic              bus_vma,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_dout_en,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              mem_rdy,
  output logic [NREG-1:0]   chip_sel
);
  import bsm_pkg::*;

  localparam int CW = fn_cnt_width(MAX_WAIT);

  bsm_state_e  st;
  logic        accept;
  logic        in_data;
  logic        stall_now;
  logic        tmo_hit;
  logic [CW-1:0] waits;

  bsm_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_rdy   (mem_rdy),
    .bus_din   (bus_din),
    .tmo_hit   (tmo_hit),
    .st        (st),
    .accept    (accept),
    .addr_q    (bus_addr),
    .rnw_q     (bus_rnw),
    .wdata_q   (bus_dout),
    .rdata_q   (rsp_rdata),
    .err_q     (rsp_err)
  );

  assign in_data   = (st == ST_DATA);
  assign stall_now = in_data && !mem_rdy;

  bsm_wait_timer #(.MAX_WAIT(MAX_WAIT)) tmr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (accept),
    .stall    (stall_now),
    .waits    (waits),
    .at_limit (tmo_hit)
  );

  assign bus_vma     = (st == ST_ADDR) || in_data;
  assign bus_dout_en = in_data && !bus_rnw;
  assign req_ready   = (st == ST_IDLE);
  assign rsp_valid   = (st == ST_DONE);

  bsm_addr_decode #(
    .ADDR_W (ADDR_W), .NREG(NREG), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
  ) dec_i (
    .addr (bus_addr),
    .qual (bus_vma),
    .sel  (chip_sel)
  );

endmodule

// File: rtl/bsm_checker.sv
module bsm_checker #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int NREG     = 3,
  parameter int MAX_WAIT = 500
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_vma,
  input logic              bus_rnw,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NREG-1:0]   chip_sel,
  input logic              bus_dout_en,
  input logic              mem_rdy,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              req_ready,
  input logic              in_data,
  input logic              tmo_hit
);
  localparam int LW = $clog2(MAX_WAIT + 4) + 1;
  logic [LW-1:0] vma_len;

  always_ff @(posedge clk) begin
    if (!rst_n || !bus_vma) vma_len <= '0;
    else if (vma_len != {LW{1'b1}}) vma_len <= vma_len + 1'b1;
  end

  AST_CS_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_sel != '0) |-> bus_vma);                                       // R4
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chip_sel));                                                 // R4
  AST_DOUT_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dout_en |-> (bus_vma && !bus_rnw && in_data));                   // R3
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && !mem_rdy && !tmo_hit) |=>
      (bus_vma && $stable(bus_addr) && $stable(bus_rnw) && $stable(chip_sel))); // R6
  AST_STALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    vma_len <= LW'(MAX_WAIT + 2));                                       // R7
  AST_ABORT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == {DATA_W{1'b1}}));           // R7
  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!bus_vma && chip_sel == '0 && !req_ready));           // R8
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);                                           // R8

endmodule

bind bus_stall_master bsm_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG), .MAX_WAIT(MAX_WAIT)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_vma    (bus_vma),
  .bus_rnw    (bus_rnw),
  .bus_addr   (bus_addr),
  .chip_sel   (chip_sel),
  .bus_dout_en(bus_dout_en),
  .mem_rdy    (mem_rdy),
  .rsp_valid  (rsp_valid),
  .rsp_err    (rsp_err),
  .rsp_rdata  (rsp_rdata),
  .req_ready  (req_ready),
  .in_data    (in_data),
  .tmo_hit    (tmo_hit)
);

// File: tb/bus_stall_master_tb.sv
module bus_stall_master_tb_top;

  localparam int MAXW = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        rsp_err;
  logic [15:0] bus_addr;
  logic        bus_rnw;
  logic        bus_vma;
  logic [7:0]  bus_dout;
  logic        bus_dout_en;
  logic [7:0]  bus_din = '0;
  logic        mem_rdy = 1'b1;
  logic [2:0]  chip_sel;

  int n_run  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bus_stall_master #(.MAX_WAIT(MAXW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .bus_addr(bus_addr), .bus_rnw(bus_rnw), .bus_vma(bus_vma),
    .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .bus_din(bus_din),
    .mem_rdy(mem_rdy), .chip_sel(chip_sel)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_sel(input logic [15:0] a);
    if (a <= 16'h1FFF) return 3'b001;
    if (a >= 16'h8000 && a < 16'h8100) return 3'b010;
    if (a >= 16'hE000) return 3'b100;
    return 3'b000;
  endfunction

  function automatic int exp_data_clks(input int low);
    return (low > MAXW ? MAXW : low) + 1;
  endfunction

  task automatic txn(input bit wr, input logic [15:0] a, input logic [7:0] wd,
                     input int low, input logic [7:0] din);
    int nd;
    bit tmo;
    nd  = exp_data_clks(low);
    tmo = (low > MAXW);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    chk(req_ready == 1'b1, "R8 ready in idle", req_ready, 1);
    @(negedge clk);
    req_valid = $urandom_range(0, 1);
    // address phase
    chk(bus_vma == 1'b1, "R2 vma addr phase", bus_vma, 1);
    chk(bus_addr == a, "R2 address", bus_addr, a);
    chk(bus_rnw == !wr, "R2 direction", bus_rnw, !wr);
    chk(bus_dout_en == 1'b0, "R3 no drive in addr phase", bus_dout_en, 0);
    chk(chip_sel == exp_sel(a), "R4 chip select", chip_sel, exp_sel(a));
    chk(req_ready == 1'b0, "R8 busy", req_ready, 0);
    for (int k = 0; k < nd; k++) begin
      @(negedge clk);
      chk(bus_vma == 1'b1 && bus_addr == a, "R6 held in data phase", bus_addr, a);
      chk(chip_sel == exp_sel(a), "R6 select held", chip_sel, exp_sel(a));
      chk(bus_dout_en == wr, "R3 drive enable", bus_dout_en, wr);
      if (wr) chk(bus_dout == wd, "R3 write byte", bus_dout, wd);
      chk(rsp_valid == 1'b0, "R5 no early response", rsp_valid, 0);
      mem_rdy = (k >= low);
      bus_din = (k >= low) ? din : ~din;
    end
    @(negedge clk);
    mem_rdy = 1'b1;
    bus_din = $urandom_range(0, 255);
    chk(rsp_valid == 1'b1, "R5 response pulse", rsp_valid, 1);
    chk(bus_vma == 1'b0 && chip_sel == 3'b000, "R8 gap", {bus_vma, chip_sel}, 0);
    chk(rsp_err == tmo, tmo ? "R7 error flag" : "R5 no error", rsp_err, tmo);
    if (tmo) chk(rsp_rdata == 8'hFF, "R7 abort value", rsp_rdata, 8'hFF);
    else if (!wr) chk(rsp_rdata == din, "R5 read data", rsp_rdata, din);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R8 single pulse", rsp_valid, 0);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] edges [12];
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    chk(bus_vma == 0 && chip_sel == 0 && bus_dout_en == 0 && rsp_valid == 0,
        "R1 reset outputs", {bus_vma, chip_sel, bus_dout_en, rsp_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && bus_vma == 1'b0, "R1 after reset", {req_ready, bus_vma}, 2);

    edges = '{16'h0000, 16'h1FFF, 16'h2000, 16'h7FFF, 16'h8000, 16'h80FF,
              16'h8100, 16'hDFFF, 16'hE000, 16'hFFFF, 16'h4242, 16'hA000};
    foreach (edges[i]) txn(i[0], edges[i], 8'h5A ^ 8'(i), 0, 8'hC3 ^ 8'(i));

    // stall sweep: R6 up to the limit, R7 beyond it
    for (int l = 0; l <= MAXW + 2; l++) begin
      txn(1'b0, 16'hE010, 8'h00, l, 8'h3C + 8'(l));
      txn(1'b1, 16'h8004, 8'h90 + 8'(l), l, 8'h00);
    end

    for (int n = 0; n < 60; n++) begin
      logic [15:0] a;
      int low;
      case ($urandom_range(0, 3))
        0: a = 16'(($urandom_range(0, 16'h1FFF)));
        1: a = 16'h8000 + 16'($urandom_range(0, 16'h1FF));
        2: a = 16'hE000 + 16'($urandom_range(0, 16'h1FFF));
        default: a = 16'($urandom);
      endcase
      low = ($urandom_range(0, 4) == 0) ? $urandom_range(MAXW - 1, MAXW + 3)
                                        : $urandom_range(0, 3);
      txn($urandom_range(0, 1), a, 8'($urandom), low, 8'($urandom));
    end

    req_valid = 1'b0;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule